// File: doc/BRIEF.md
# Splittable 16-bit timer/counter

This block is a programmable timer/counter for a small microcontroller. It runs either as one 16-bit counter or as two independent 8-bit counters. The count clock is chosen by software. It is either a tap of a free-running internal prescaler (divide by 1, 4, 16 or 64) or the rising edges of an external clock pin, which is how it counts events or divides an outside clock.

Each counter compares itself against a reference value. When a count advance finds the counter equal to its reference, the counter returns to zero, a one-cycle interrupt request is raised and a clock output toggles. The output frequency is therefore set by the reference value. The toggle of the low (or only) counter also serves as the shift clock for a serial port.

Software reaches the block through a small register bus. There is a mode register, a reference register and a read-only count register. Writes and reads use separate addresses.

Top module: `tmr_split16`

## Requirements
- R1: In 16-bit mode (split=0), every count tick in which the count equals the 16-bit reference sets the count to 0. Every other tick increments it, wrapping from 0xFFFF to 0, so the match period is reference+1 ticks. A carry passes from the low byte into the high byte.
- R2: In split mode (split=1), the low byte uses reference bits [7:0] and the high byte uses reference bits [15:8]. Each byte follows the R1 rule on its own, wrapping within 8 bits, and no carry passes between the bytes.
- R3: A match on a lane drives that lane's interrupt output (irq[0] for the low or 16-bit counter, irq[1] for the high byte) high for exactly the cycle after the matching tick. In that cycle the lane's count reads 0.
- R4: Each match toggles the clock output of its lane (clk_out[0] or clk_out[1]). The clock outputs change at no other time.
- R5: sclk_out always equals clk_out[0].
- R6: The mode register is written at address 0. Bit 0 is run, bit 1 is split, bits [3:2] select the prescaler and bit 4 selects the external source. With bit 4 at 0, a tick occurs in the cycles where a free-running 6-bit cycle counter, cleared by reset, has all of its low bits set for the selected divisor: none for 0 (divide by 1), 2 for 1 (divide by 4), 4 for 2 (divide by 16) and 6 for 3 (divide by 64).
- R7: With mode bit 4 at 1, ext_in passes through two synchronizing flip-flops and an edge register. Each rising edge gives exactly one tick, in the third rising clock edge after the edge at which ext_in is first sampled high.
- R8: While run is 0, no count changes, interrupts or toggles happen, except for the reload in R9.
- R9: A write to the reference register (address 1) while run is 0 sets the count to 0. The same write while run is 1 leaves the count running.
- R10: After synchronous reset, the mode, reference and count registers are 0, and irq, clk_out and sclk_out are 0.
- R11: rdata shows the mode register (zero-extended) at raddr 0, the reference at 1, the count at 2 and 0 at 3.
- R12: In 16-bit mode, irq[1] stays 0 and clk_out[1] holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Register write strobe |
| waddr | input | 2 | Write address: 0 mode, 1 reference |
| wdata | input | 16 | Write data |
| raddr | input | 2 | Read address: 0 mode, 1 reference, 2 count |
| rdata | output | 16 | Read data |
| ext_in | input | 1 | External count clock / event input |
| irq | output | 2 | Match interrupt requests, [0] low or 16-bit lane, [1] high lane |
| clk_out | output | 2 | Toggle outputs per lane |
| sclk_out | output | 1 | Shift clock for the serial port |

## Verification
A wrong count, reference or prescaler phase shows up on the count read port within the same cycle. It shifts the interrupt and toggle outputs no later than the next match. A bad carry or a missing split separation shows up as a high byte that moves at the wrong tick. A fault in the external edge path shows up as a tick that comes too early, too late or twice, and the count read port reveals it within one cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int PRE_W = 6;

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_REF  = 2'd1;
    localparam logic [1:0] ADDR_CNT  = 2'd2;

    typedef enum logic [1:0] {
        DIV1  = 2'd0,
        DIV4  = 2'd1,
        DIV16 = 2'd2,
        DIV64 = 2'd3
    } pre_sel_e;

    typedef struct packed {
        logic     ext;
        pre_sel_e pre;
        logic     split;
        logic     run;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    function automatic logic [PRE_W-1:0] pre_mask(input pre_sel_e sel);
        case (sel)
            DIV1:    pre_mask = 6'h00;
            DIV4:    pre_mask = 6'h03;
            DIV16:   pre_mask = 6'h0F;
            default: pre_mask = 6'h3F;
        endcase
    endfunction

endpackage

// File: rtl/tmr_clk_src.sv
module tmr_clk_src
    import tmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ext_in,
    input  mode_t mode,
    output logic  tick
);
    logic [PRE_W-1:0] pre_q;
    logic [2:0]       sync_q;
    logic             rise;
    logic             int_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            sync_q <= '0;
        end else begin
            pre_q  <= pre_q + 1'b1;
            sync_q <= {sync_q[1:0], ext_in};
        end
    end

    always_comb begin
        rise     = sync_q[1] & ~sync_q[2];
        int_tick = (pre_q & pre_mask(mode.pre)) == pre_mask(mode.pre);
        tick     = mode.ext ? rise : int_tick;
    end
endmodule

// File: rtl/tmr_lane.sv
module tmr_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] ref_val,
    output logic [W-1:0] cnt,
    output logic         eq
);
    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    assign eq = (cnt == ref_val);
endmodule

// File: rtl/tmr_event.sv
module tmr_event (
    input  logic clk,
    input  logic rst,
    input  logic match,
    output logic irq,
    output logic tog
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
            tog <= 1'b0;
        end else begin
            irq <= match;
            if (match) tog <= ~tog;
        end
    end
endmodule

// File: rtl/tmr_split16.sv
module tmr_split16
    import tmr_pkg::*;
#(
    parameter int HALF_W = 8,
    localparam int W     = 2 * HALF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [1:0]   waddr,
    input  logic [W-1:0] wdata,
    input  logic [1:0]   raddr,
    output logic [W-1:0] rdata,
    input  logic         ext_in,
    output logic [1:0]   irq,
    output logic [1:0]   clk_out,
    output logic         sclk_out
);
    mode_t        mode_q;
    logic [W-1:0] ref_q;
    logic         tick;
    logic         adv;
    logic         ref_wr;
    logic         reload;
    logic         match16;
    logic         lo_full;
    logic [1:0]   eq;
    logic [1:0]   clr;
    logic [1:0]   inc;
    logic [1:0]   evt;
    logic [HALF_W-1:0] cnt_h [2];
    logic [W-1:0] cnt_all;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            ref_q  <= '0;
        end else if (we) begin
            if (waddr == ADDR_MODE) mode_q <= mode_t'(wdata[MODE_W-1:0]);
            if (waddr == ADDR_REF)  ref_q  <= wdata;
        end
    end

    tmr_clk_src u_src (
        .clk    (clk),
        .rst    (rst),
        .ext_in (ext_in),
        .mode   (mode_q),
        .tick   (tick)
    );

    always_comb begin
        ref_wr  = we && (waddr == ADDR_REF);
        reload  = ref_wr && !mode_q.run;
        adv     = mode_q.run && tick;
        match16 = eq[0] && eq[1];
        lo_full = &cnt_h[0];
        if (mode_q.split) begin
            evt[0] = adv && eq[0];
            evt[1] = adv && eq[1];
            inc[0] = adv && !eq[0];
            inc[1] = adv && !eq[1];
        end else begin
            evt[0] = adv && match16;
            evt[1] = 1'b0;
            inc[0] = adv && !match16;
            inc[1] = adv && !match16 && lo_full;
        end
        clr[0] = reload || (mode_q.split ? evt[0] : evt[0]);
        clr[1] = reload || (mode_q.split ? evt[1] : evt[0]);
    end

    for (genvar g = 0; g < 2; g++) begin : g_lane
        tmr_lane #(.W(HALF_W)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .clr     (clr[g]),
            .inc     (inc[g]),
            .ref_val (ref_q[g*HALF_W +: HALF_W]),
            .cnt     (cnt_h[g]),
            .eq      (eq[g])
        );

        tmr_event u_evt (
            .clk   (clk),
            .rst   (rst),
            .match (evt[g]),
            .irq   (irq[g]),
            .tog   (clk_out[g])
        );
    end

    assign cnt_all  = {cnt_h[1], cnt_h[0]};
    assign sclk_out = clk_out[0];

    always_comb begin
        case (raddr)
            ADDR_MODE: rdata = {{(W-MODE_W){1'b0}}, mode_q};
            ADDR_REF:  rdata = ref_q;
            ADDR_CNT:  rdata = cnt_all;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_split16_chk.sv
module tmr_split16_chk #(
    parameter int HALF_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              run,
    input logic              split,
    input logic              ref_wr,
    input logic [2*HALF_W-1:0] cnt,
    input logic [1:0]        irq,
    input logic [1:0]        clk_out
);
    p_irq_cnt_zero_r3: assert property (@(posedge clk) disable iff (rst)
        irq[0] |-> (cnt[HALF_W-1:0] == '0));

    p_hi_irq_cnt_zero_r3: assert property (@(posedge clk) disable iff (rst)
        irq[1] |-> (cnt[2*HALF_W-1:HALF_W] == '0));

    p_toggle_on_irq_r4: assert property (@(posedge clk) disable iff (rst)
        irq[0] |-> (clk_out[0] != $past(clk_out[0])));

    p_toggle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !irq[0] |-> $stable(clk_out[0]));

    p_hi_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (!split && $past(!split)) |-> (!irq[1] && $stable(clk_out[1])));

    p_stop_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!run && $past(!run) && !$past(ref_wr)) |-> $stable(cnt));
endmodule

bind tmr_split16 tmr_split16_chk #(.HALF_W(HALF_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .run     (mode_q.run),
    .split   (mode_q.split),
    .ref_wr  (ref_wr),
    .cnt     (cnt_all),
    .irq     (irq),
    .clk_out (clk_out)
);

// File: tb/tmr_split16_tb.sv
module tmr_split16_tb_top;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [1:0]  waddr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  raddr = '0;
    logic [15:0] rdata;
    logic        ext_in = 1'b0;
    logic [1:0]  irq;
    logic [1:0]  clk_out;
    logic        sclk_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    bit started = 0;
    string phase = "R10";

    tmr_split16 dut_i (
        .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rdata), .ext_in(ext_in), .irq(irq),
        .clk_out(clk_out), .sclk_out(sclk_out)
    );

    always #(CLK_PER/2) clk = ~clk;

    // behavioural reference model
    int        m_cyc, m_cnt, m_ref, m_lo, m_hi, m_n;
    bit [4:0]  m_mode;
    bit        m_s1, m_s2, m_s3, m_rise, m_tk, m_run_old;
    bit [1:0]  m_irq, m_out;

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_cyc = 0; m_cnt = 0; m_ref = 0; m_mode = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_irq = 0; m_out = 0;
        end else begin
            m_rise = m_s2 && !m_s3;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_in;
            m_n = 1 << (2 * m_mode[3:2]);
            m_tk = m_mode[4] ? m_rise : ((m_cyc % m_n) == m_n - 1);
            m_cyc = m_cyc + 1;
            m_irq = 0;
            if (m_mode[0] && m_tk) begin
                if (!m_mode[1]) begin
                    if (m_cnt == m_ref) begin
                        m_cnt = 0; m_irq[0] = 1; m_out[0] = !m_out[0];
                    end else m_cnt = (m_cnt + 1) & 16'hFFFF;
                end else begin
                    m_lo = m_cnt & 255; m_hi = m_cnt >> 8;
                    if (m_lo == (m_ref & 255)) begin
                        m_lo = 0; m_irq[0] = 1; m_out[0] = !m_out[0];
                    end else m_lo = (m_lo + 1) & 255;
                    if (m_hi == (m_ref >> 8)) begin
                        m_hi = 0; m_irq[1] = 1; m_out[1] = !m_out[1];
                    end else m_hi = (m_hi + 1) & 255;
                    m_cnt = (m_hi << 8) | m_lo;
                end
            end
            m_run_old = m_mode[0];
            if (we && waddr == 2'd0) m_mode = wdata[4:0];
            if (we && waddr == 2'd1) begin
                m_ref = wdata;
                if (!m_run_old) m_cnt = 0;
            end
        end
    end

    task automatic chk(string what, string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: actual %0h expected %0h", req, what, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            chk("irq", rst ? "R10" : "R3", irq, m_irq);
            chk("clk_out", rst ? "R10" : "R4", clk_out, m_out);
            chk("sclk_out", "R5", sclk_out, m_out[0]);
            case (raddr)
                2'd0: chk("rdata mode", "R11", rdata, m_mode);
                2'd1: chk("rdata ref", "R11", rdata, m_ref);
                2'd2: chk("rdata count", phase, rdata, m_cnt);
                default: chk("rdata none", "R11", rdata, 0);
            endcase
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        we = 1; waddr = a; wdata = d;
        @(posedge clk); #1;
        we = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // read address: mostly count, sometimes the others (R11)
    int rd_step = 0;
    always @(posedge clk) begin
        #1;
        rd_step++;
        raddr = (rd_step % 8 < 5) ? 2'd2 : 2'((rd_step % 8) - 4);
    end

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; ext_in = 1;
            idle(i % 3);
            @(posedge clk); #1; ext_in = 0;
            idle(i % 4);
        end
    endtask

    initial begin
        idle(3);
        phase = "R10";
        idle(1);
        rst = 0;
        // R1: 16-bit, divide by 1, reference 5 written while stopped
        phase = "R1";
        wr(2'd1, 16'd5);
        wr(2'd0, 16'h0001);
        idle(40);
        // R6: prescaler taps
        phase = "R6";
        wr(2'd0, 16'h0005); idle(80);
        wr(2'd1, 16'd3);     idle(80);
        wr(2'd0, 16'h0009); idle(300);
        wr(2'd1, 16'd2);
        wr(2'd0, 16'h000D); idle(700);
        // R8: stop holds the count
        phase = "R8";
        wr(2'd0, 16'h0000); idle(30);
        // R9: reload while stopped, no reload while running
        phase = "R9";
        wr(2'd0, 16'h0001); wr(2'd1, 16'd40); idle(10);
        wr(2'd1, 16'd20); idle(60);
        wr(2'd0, 16'h0000); idle(3);
        wr(2'd1, 16'd9); idle(5);
        // R2 / R12: split mode, independent halves
        phase = "R2";
        wr(2'd1, 16'h0302);
        wr(2'd0, 16'h0003); idle(100);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h01FF);
        wr(2'd0, 16'h0003); idle(600);
        // R1: 16-bit carry across the byte boundary; R12 quiet high lane
        phase = "R1";
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0120);
        wr(2'd0, 16'h0001); idle(700);
        // R1: reference 0, match every tick
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'h0001); idle(20);
        // R7: external edges, 16-bit then split
        phase = "R7";
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'd4);
        wr(2'd0, 16'h0011); ext_pulses(40);
        wr(2'd0, 16'h0010);
        wr(2'd1, 16'h0203);
        wr(2'd0, 16'h0013); ext_pulses(30);
        idle(5);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PER * 150000);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired in phase %s: actual running expected finished", phase);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule